// File: doc/BRIEF.md
# TLB Invalidation Sweep Engine

This block removes translations from a TLB entry array. The array is split into two regions. The set-associative region holds `WAYS` ways of `SETS` lines, and every entry in it shares one page size. The variable-page region follows it, holds `VAR_N` entries, and each of its entries stores its own page size. A command selects which entries the engine visits and which rule decides whether an entry is dropped. The engine then walks the chosen entries one per clock through a read-modify-write pipeline. For each visited entry that is present and meets the rule, it writes the entry back with only its exist bit cleared.

Three command kinds are accepted. The first is the opcode-driven invalidate, which has seven match rules built from the global bit, the ASID and a page compare whose width depends on the page size. The second is an index-driven clear that drops only non-global entries of the current ASID. The third is an index-driven flush that drops every visited entry. For the two index-driven kinds, an index inside the set-associative region selects one line across all ways, and an index inside the variable region selects the whole variable region. The array itself sits outside the block behind a simple dual-port interface with a one-cycle read latency.

Top module: `tlb_inv_sweep`

## Requirements
- R1: After synchronous reset, busy, done, illegal, arr_rd_en and arr_we are all 0.
- R2: Kind 0 (invalidate) with opcode 0 or opcode 1 clears the exist bit of every entry in both regions.
- R3: Kind 0 with opcode 2 clears only entries whose global bit is 1. With opcode 3 it clears only entries whose global bit is 0.
- R4: Kind 0 with opcode 4 clears entries whose global bit is 0 and whose stored ASID equals cmd_asid.
- R5: Kind 0 with opcode 5 clears non-global entries that match both ASID and page. Opcode 6 clears entries that match the page and are either global or match cmd_asid.
- R6: An entry matches the page when cmd_va shifted right by ps+1 equals the stored VPPN shifted right by ps+1-13. In the variable region ps is the entry's own size field. In the set-associative region ps is the shared_ps input, and the entry's size field is ignored.
- R7: A command is illegal if cmd_priv is 0, if kind is 3, or if kind 0 carries an opcode above 6. An illegal command pulses illegal for one cycle, starts no sweep and changes no entry.
- R8: Kind 1 (clear) uses the current ASID from cur_asid. If cmd_index is below SETS*WAYS, it clears non-global matching-ASID entries at way*SETS + (cmd_index mod SETS) for every way. If cmd_index is inside the variable region, it clears the same kind of entries across the whole variable region.
- R9: Kind 2 (flush) selects entries by cmd_index in the same way as kind 1, but clears every selected entry with no ASID or global test.
- R10: Entry layout is exist [52], global [51], ASID [50:41], VPPN (address bits 47:13) [40:6] and page size [5:0]. Only present entries that match the rule are written. A written entry keeps every field except exist, which becomes 0.
- R11: For a command that visits N entries (all entries for kind 0, WAYS for one line, VAR_N for the variable region), busy is high for N+3 cycles after the accepting edge. done is then high for exactly one cycle, in the cycle where busy first reads low.
- R12: A command presented while busy is high is ignored. It has no effect on the array or on the timing.
- R13: A kind 1 or kind 2 command whose cmd_index is at or above SETS*WAYS+VAR_N visits no entry. busy stays low, and done pulses in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_kind | input | 2 | 0 invalidate, 1 ASID clear, 2 flush, 3 reserved |
| cmd_op | input | 5 | Invalidate opcode (kind 0) |
| cmd_priv | input | 1 | 1 when issued at the most privileged level |
| cmd_asid | input | 10 | ASID operand for kind 0 |
| cmd_va | input | 48 | Virtual address operand for page rules |
| cmd_index | input | AW | Index operand for kinds 1 and 2 |
| cur_asid | input | 10 | Current ASID used by kind 1 |
| shared_ps | input | 6 | Page size of the set-associative region |
| arr_rd_en | output | 1 | Array read strobe |
| arr_raddr | output | AW | Array read address |
| arr_rdata | input | 53 | Array read data, valid one cycle after the strobe |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | AW | Array write address |
| arr_wdata | output | 53 | Array write data |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for a rejected command |

## Verification
The bench plants entries on one line and in the variable region that share a page but differ in ASID, global bit and page size. A design that used the shared size in the variable region, or a fixed shift, would drop the wrong planted entry or miss the large-page one. Line-mode commands use an index with nonzero way bits, so a design that skipped the modulo would visit the wrong line. An index past the array end checks that such a design does not hang or wander. A flush carries an extra command injected in its middle, which an engine that accepted commands while busy would act on, wiping the array.

// File: rtl/tlb_inv_pkg.sv
package tlb_inv_pkg;
  localparam int VA_W   = 48;
  localparam int PG_LSB = 13;
  localparam int VPPN_W = VA_W - PG_LSB;
  localparam int ASID_W = 10;
  localparam int PS_W   = 6;

  typedef struct packed {
    logic              exist;
    logic              glob;
    logic [ASID_W-1:0] asid;
    logic [VPPN_W-1:0] vppn;
    logic [PS_W-1:0]   ps;
  } tlb_ent_t;

  localparam int ENT_W = $bits(tlb_ent_t);

  typedef enum logic [1:0] {
    CK_INV   = 2'd0,
    CK_CLR   = 2'd1,
    CK_FLUSH = 2'd2,
    CK_RSVD  = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    SW_ALL,
    SW_LINE,
    SW_VAR,
    SW_NONE
  } sweep_e;

  typedef enum logic [2:0] {
    RULE_ANY,
    RULE_G,
    RULE_NG,
    RULE_ASID,
    RULE_ASID_PG,
    RULE_GA_PG
  } rule_e;
endpackage

// File: rtl/tlb_inv_addr.sv
module tlb_inv_addr
  import tlb_inv_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int WAYS  = 8,
  parameter int VAR_N = 64,
  localparam int VBASE = SETS * WAYS,
  localparam int TOTAL = VBASE + VAR_N,
  localparam int AW    = $clog2(TOTAL),
  localparam int CW    = $clog2(TOTAL + 1),
  localparam int LW    = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  sweep_e          mode,
  input  logic [CW-1:0]   cnt,
  input  logic [LW-1:0]   line,
  output logic [AW-1:0]   addr,
  output logic            last
);
  always_comb begin
    case (mode)
      SW_LINE: begin
        addr = AW'(32'(cnt) * SETS + 32'(line));
        last = (32'(cnt) == WAYS - 1);
      end
      SW_VAR: begin
        addr = AW'(VBASE + 32'(cnt));
        last = (32'(cnt) == VAR_N - 1);
      end
      default: begin
        addr = AW'(cnt);
        last = (32'(cnt) == TOTAL - 1);
      end
    endcase
  end
endmodule

// File: rtl/tlb_inv_match.sv
module tlb_inv_match
  import tlb_inv_pkg::*;
(
  input  rule_e             rule,
  input  tlb_ent_t          ent,
  input  logic [ASID_W-1:0] asid,
  input  logic [VA_W-1:0]   va,
  input  logic [PS_W-1:0]   ps,
  output logic              hit
);
  logic [VA_W-1:0] keep;
  logic [VA_W-1:0] stored;
  logic            asid_eq;
  logic            page_eq;
  logic            sel;

  always_comb begin
    keep    = {VA_W{1'b1}} << ({1'b0, ps} + 7'd1);
    stored  = {ent.vppn, {PG_LSB{1'b0}}};
    page_eq = ((va ^ stored) & keep) == '0;
    asid_eq = (ent.asid == asid);
    case (rule)
      RULE_G:       sel = ent.glob;
      RULE_NG:      sel = !ent.glob;
      RULE_ASID:    sel = !ent.glob && asid_eq;
      RULE_ASID_PG: sel = !ent.glob && asid_eq && page_eq;
      RULE_GA_PG:   sel = (ent.glob || asid_eq) && page_eq;
      default:      sel = 1'b1;
    endcase
    hit = ent.exist && sel;
  end
endmodule

// File: rtl/tlb_inv_sweep.sv
module tlb_inv_sweep
  import tlb_inv_pkg::*;
#(
  parameter int SETS  = 256,
  parameter int WAYS  = 8,
  parameter int VAR_N = 64,
  localparam int VBASE = SETS * WAYS,
  localparam int TOTAL = VBASE + VAR_N,
  localparam int AW    = $clog2(TOTAL),
  localparam int CW    = $clog2(TOTAL + 1),
  localparam int LW    = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_kind,
  input  logic [4:0]        cmd_op,
  input  logic              cmd_priv,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic [VA_W-1:0]   cmd_va,
  input  logic [AW-1:0]     cmd_index,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [PS_W-1:0]   shared_ps,
  output logic              arr_rd_en,
  output logic [AW-1:0]     arr_raddr,
  input  logic [ENT_W-1:0]  arr_rdata,
  output logic              arr_we,
  output logic [AW-1:0]     arr_waddr,
  output logic [ENT_W-1:0]  arr_wdata,
  output logic              busy,
  output logic              done,
  output logic              illegal
);
  // command decode
  logic   dec_legal;
  rule_e  dec_rule;
  sweep_e dec_mode;

  always_comb begin
    dec_legal = cmd_priv;
    dec_rule  = RULE_ANY;
    dec_mode  = SW_ALL;
    case (cmd_kind)
      CK_INV: begin
        case (cmd_op)
          5'd0, 5'd1: dec_rule = RULE_ANY;
          5'd2:       dec_rule = RULE_G;
          5'd3:       dec_rule = RULE_NG;
          5'd4:       dec_rule = RULE_ASID;
          5'd5:       dec_rule = RULE_ASID_PG;
          5'd6:       dec_rule = RULE_GA_PG;
          default:    dec_legal = 1'b0;
        endcase
      end
      CK_CLR, CK_FLUSH: begin
        dec_rule = (cmd_kind == CK_CLR) ? RULE_ASID : RULE_ANY;
        if (32'(cmd_index) < VBASE)      dec_mode = SW_LINE;
        else if (32'(cmd_index) < TOTAL) dec_mode = SW_VAR;
        else                             dec_mode = SW_NONE;
      end
      default: dec_legal = 1'b0;
    endcase
  end

  // latched operands
  rule_e             r_rule;
  sweep_e            r_mode;
  logic [ASID_W-1:0] r_asid;
  logic [VA_W-1:0]   r_va;
  logic [PS_W-1:0]   r_ps;
  logic [LW-1:0]     r_line;

  // sweep state
  logic          issuing;
  logic [CW-1:0] cnt;
  logic [AW-1:0] gen_addr;
  logic          gen_last;
  logic          rd_last;
  logic          p1_v;
  logic          p1_last;
  logic [AW-1:0] p1_addr;
  logic          w_last;

  wire accept = cmd_valid && !busy;

  tlb_inv_addr #(.SETS(SETS), .WAYS(WAYS), .VAR_N(VAR_N)) u_addr (
    .mode (r_mode),
    .cnt  (cnt),
    .line (r_line),
    .addr (gen_addr),
    .last (gen_last)
  );

  // compare stage
  tlb_ent_t        rd_ent;
  tlb_ent_t        wr_ent;
  logic [PS_W-1:0] p1_ps;
  logic            p1_hit;

  always_comb begin
    rd_ent       = tlb_ent_t'(arr_rdata);
    p1_ps        = (32'(p1_addr) >= VBASE) ? rd_ent.ps : r_ps;
    wr_ent       = rd_ent;
    wr_ent.exist = 1'b0;
  end

  tlb_inv_match u_match (
    .rule (r_rule),
    .ent  (rd_ent),
    .asid (r_asid),
    .va   (r_va),
    .ps   (p1_ps),
    .hit  (p1_hit)
  );

  // control path
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      illegal   <= 1'b0;
      issuing   <= 1'b0;
      cnt       <= '0;
      arr_rd_en <= 1'b0;
      rd_last   <= 1'b0;
      p1_v      <= 1'b0;
      p1_last   <= 1'b0;
      arr_we    <= 1'b0;
      w_last    <= 1'b0;
    end else begin
      done      <= 1'b0;
      illegal   <= 1'b0;
      arr_rd_en <= issuing;
      p1_v      <= arr_rd_en;
      p1_last   <= arr_rd_en && rd_last;
      arr_we    <= p1_v && p1_hit;
      w_last    <= p1_v && p1_last;
      if (issuing) begin
        rd_last <= gen_last;
        cnt     <= cnt + 1'b1;
        if (gen_last) issuing <= 1'b0;
      end
      if (w_last) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
      if (accept) begin
        if (!dec_legal)             illegal <= 1'b1;
        else if (dec_mode == SW_NONE) done  <= 1'b1;
        else begin
          busy    <= 1'b1;
          issuing <= 1'b1;
          cnt     <= '0;
        end
      end
    end
  end

  // data path, no reset
  always_ff @(posedge clk) begin
    if (accept && dec_legal) begin
      r_rule <= dec_rule;
      r_mode <= dec_mode;
      r_asid <= (cmd_kind == CK_CLR) ? cur_asid : cmd_asid;
      r_va   <= cmd_va;
      r_ps   <= shared_ps;
      r_line <= LW'(32'(cmd_index) % SETS);
    end
    if (issuing) arr_raddr <= gen_addr;
    p1_addr   <= arr_raddr;
    arr_waddr <= p1_addr;
    arr_wdata <= wr_ent;
  end
endmodule

// File: rtl/tlb_inv_sweep_chk.sv
module tlb_inv_sweep_chk #(
  parameter int AW    = 12,
  parameter int ENT_W = 53
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             done,
  input logic             illegal,
  input logic             arr_rd_en,
  input logic             arr_we,
  input logic [AW-1:0]    arr_raddr,
  input logic [AW-1:0]    arr_waddr,
  input logic [ENT_W-1:0] arr_rdata,
  input logic [ENT_W-1:0] arr_wdata
);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_fall_done_R11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!arr_rd_en && !arr_we));

  assert_exist_cleared_R10: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !arr_wdata[ENT_W-1]);

  assert_fields_kept_R10: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (arr_wdata[ENT_W-2:0] == $past(arr_rdata[ENT_W-2:0])));

  assert_write_addr_R10: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (arr_waddr == $past(arr_raddr, 2)));

  assert_illegal_idle_R7: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !busy);
endmodule

bind tlb_inv_sweep tlb_inv_sweep_chk #(.AW(AW), .ENT_W(tlb_inv_pkg::ENT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .illegal   (illegal),
  .arr_rd_en (arr_rd_en),
  .arr_we    (arr_we),
  .arr_raddr (arr_raddr),
  .arr_waddr (arr_waddr),
  .arr_rdata (arr_rdata),
  .arr_wdata (arr_wdata)
);

// File: tb/tlb_inv_sweep_tb.sv
module tlb_inv_sweep_tb;
  timeunit 1ns;
  timeprecision 1ps;
  import tlb_inv_pkg::*;

  localparam int SETS  = 256;
  localparam int WAYS  = 8;
  localparam int VAR_N = 64;
  localparam int VBASE = SETS * WAYS;
  localparam int TOTAL = VBASE + VAR_N;
  localparam int AW    = $clog2(TOTAL);
  localparam int SPS   = 12;
  localparam logic [47:0] VA0 = 48'h0000_1234_5000;
  localparam logic [34:0] PV  = VA0[47:13];

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic              cmd_valid = 1'b0;
  logic [1:0]        cmd_kind = '0;
  logic [4:0]        cmd_op = '0;
  logic              cmd_priv = 1'b0;
  logic [9:0]        cmd_asid = '0;
  logic [47:0]       cmd_va = '0;
  logic [AW-1:0]     cmd_index = '0;
  logic [9:0]        cur_asid = '0;
  logic [5:0]        shared_ps = 6'(SPS);
  logic              arr_rd_en, arr_we, busy, done, illegal;
  logic [AW-1:0]     arr_raddr, arr_waddr;
  logic [ENT_W-1:0]  arr_rdata, arr_wdata;

  tlb_inv_sweep #(.SETS(SETS), .WAYS(WAYS), .VAR_N(VAR_N)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .cmd_op(cmd_op), .cmd_priv(cmd_priv), .cmd_asid(cmd_asid), .cmd_va(cmd_va),
    .cmd_index(cmd_index), .cur_asid(cur_asid), .shared_ps(shared_ps),
    .arr_rd_en(arr_rd_en), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .busy(busy), .done(done), .illegal(illegal)
  );

  int n_checks = 0;
  int n_err    = 0;
  logic [ENT_W-1:0] mem   [TOTAL];
  logic [ENT_W-1:0] ref_m [TOTAL];
  logic             fill_req = 1'b0;
  int unsigned      fill_seed = 0;

  function automatic logic [ENT_W-1:0] ent_of(int unsigned seed, int i);
    int unsigned r;
    logic [9:0]  a;
    logic [5:0]  ps;
    r = seed * 32'h9E3779B1 ^ (32'(i) * 32'h85EBCA6B);
    r = r ^ (r >> 15);
    r = r * 32'h2C1B3C6D;
    r = r ^ (r >> 12);
    case (r[5:4])
      2'd0: a = 10'd5;
      2'd1: a = 10'd6;
      2'd2: a = 10'd7;
      default: a = 10'd300;
    endcase
    if (i >= VBASE) ps = (r[9:8] == 2'd1) ? 6'd14 : ((r[9:8] == 2'd2) ? 6'd21 : 6'd12);
    else            ps = r[15:10];
    if (i == 1*SETS + 40) return {1'b1, 1'b0, 10'd5, PV, 6'd33};
    if (i == 2*SETS + 40) return {1'b1, 1'b1, 10'd9, PV, 6'd0};
    if (i == 3*SETS + 40) return {1'b1, 1'b0, 10'd6, PV, 6'd12};
    if (i == VBASE + 3)   return {1'b1, 1'b0, 10'd5, PV ^ 35'hFF, 6'd21};
    if (i == VBASE + 4)   return {1'b1, 1'b0, 10'd5, PV ^ 35'h1, 6'd12};
    return {r[2:0] != 3'd0, r[3], a, 35'h7_0000_0000 | 35'(r[7:6]) << 20 | 35'(r[19:16]), ps};
  endfunction

  // bench-side array with one-cycle read latency
  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < TOTAL; i++) mem[i] <= ent_of(fill_seed, i);
    end else begin
      if (arr_rd_en) arr_rdata <= mem[arr_raddr];
      if (arr_we)    mem[arr_waddr] <= arr_wdata;
    end
  end

  task automatic check(bit ok, string msg);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic refill(int unsigned seed);
    @(negedge clk);
    fill_seed = seed;
    fill_req  = 1'b1;
    for (int i = 0; i < TOTAL; i++) ref_m[i] = ent_of(seed, i);
    @(negedge clk);
    fill_req = 1'b0;
  endtask

  function automatic bit ref_hit(int i, logic [ENT_W-1:0] e, int kind, int op,
                                 int asid, longint unsigned va, int idx);
    bit              g  = e[ENT_W-2];
    int              a  = int'(e[50:41]);
    longint unsigned vp = 64'(e[40:6]);
    int              ps = (i >= VBASE) ? int'(e[5:0]) : SPS;
    bit              aeq;
    bit              peq;
    bit              sc;
    aeq = (a == asid);
    peq = ((va >> (ps + 1)) == (vp >> (ps + 1 - 13)));
    if (!e[ENT_W-1]) return 1'b0;
    if (idx < VBASE)      sc = (i < VBASE) && ((i % SETS) == (idx % SETS));
    else if (idx < TOTAL) sc = (i >= VBASE);
    else                  sc = 1'b0;
    if (kind == 1) return sc && !g && aeq;
    if (kind == 2) return sc;
    case (op)
      0, 1: return 1'b1;
      2:    return g;
      3:    return !g;
      4:    return !g && aeq;
      5:    return !g && aeq && peq;
      6:    return (g || aeq) && peq;
      default: return 1'b0;
    endcase
  endfunction

  task automatic run_cmd(string tag, int kind, int op, bit priv, int asid,
                         longint unsigned va, int idx, bit inject);
    bit legal;
    int len;
    int last_c;
    bit bad;
    bit e_busy, e_done, e_ill;
    legal = priv && ((kind == 1) || (kind == 2) || (kind == 0 && op <= 6));
    if (kind == 0)        len = TOTAL;
    else if (idx < VBASE) len = WAYS;
    else if (idx < TOTAL) len = VAR_N;
    else                  len = 0;
    if (legal)
      for (int i = 0; i < TOTAL; i++)
        if (ref_hit(i, ref_m[i], kind, op, asid, va, idx)) ref_m[i][ENT_W-1] = 1'b0;
    last_c = (!legal || len == 0) ? 1 : len + 4;
    @(negedge clk);
    cmd_kind  = 2'(kind);
    cmd_op    = 5'(op);
    cmd_priv  = priv;
    cmd_asid  = 10'(asid);
    cur_asid  = 10'(asid);
    cmd_va    = 48'(va);
    cmd_index = AW'(idx);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    bad = 1'b0;
    for (int c = 1; c <= last_c; c++) begin
      if (c > 1) @(negedge clk);
      if (inject && c == 5) begin
        cmd_kind = 2'd0; cmd_op = 5'd0; cmd_priv = 1'b1; cmd_valid = 1'b1;
      end
      if (inject && c == 6) cmd_valid = 1'b0;
      e_busy = legal && (len > 0) && (c <= len + 3);
      e_done = legal && (c == last_c);
      e_ill  = !legal && (c == 1);
      if (!bad && (busy !== e_busy || done !== e_done || illegal !== e_ill)) begin
        bad = 1'b1;
        $display("FAIL R11 %s cycle %0d busy/done/illegal got %b%b%b exp %b%b%b",
                 tag, c, busy, done, illegal, e_busy, e_done, e_ill);
      end
    end
    n_checks++;
    if (bad) n_err++;
    @(negedge clk);
    bad = 1'b0;
    for (int i = 0; i < TOTAL; i++) begin
      if (!bad && mem[i] !== ref_m[i]) begin
        bad = 1'b1;
        $display("FAIL %s R10 entry %0d got %h exp %h", tag, i, mem[i], ref_m[i]);
      end
    end
    n_checks++;
    if (bad) n_err++;
  endtask

  initial begin
    #2_000_000;
    $display("FAIL R11 watchdog expired");
    n_checks++;
    n_err++;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(busy === 1'b0 && done === 1'b0 && illegal === 1'b0 &&
          arr_rd_en === 1'b0 && arr_we === 1'b0,
          $sformatf("R1 reset outputs got %b%b%b%b%b exp 00000",
                    busy, done, illegal, arr_rd_en, arr_we));

    refill(1);  run_cmd("R2 op0 all",        0, 0, 1, 5, 0, 0, 0);
    refill(2);  run_cmd("R2 op1 all",        0, 1, 1, 5, 0, 0, 0);
    refill(3);  run_cmd("R3 op2 global",     0, 2, 1, 5, 0, 0, 0);
    refill(4);  run_cmd("R3 op3 nonglobal",  0, 3, 1, 5, 0, 0, 0);
    refill(5);  run_cmd("R4 op4 asid",       0, 4, 1, 6, 0, 0, 0);
    refill(6);  run_cmd("R5 R6 op5 page",    0, 5, 1, 5, VA0, 0, 0);
    refill(7);  run_cmd("R5 R6 op6 page",    0, 6, 1, 5, VA0, 0, 0);
    refill(8);
    run_cmd("R7 op7",        0, 7,  1, 5, 0, 0, 0);
    run_cmd("R7 op31",       0, 31, 1, 5, 0, 0, 0);
    run_cmd("R7 kind3",      3, 0,  1, 5, 0, 0, 0);
    run_cmd("R7 no priv",    0, 0,  0, 5, 0, 0, 0);
    run_cmd("R7 no priv clr", 2, 0, 0, 5, 0, 40, 0);
    run_cmd("R8 clr line",   1, 0, 1, 5, 0, 2*SETS + 40, 0);
    run_cmd("R8 clr var",    1, 0, 1, 5, 0, VBASE + 5, 0);
    refill(9);
    run_cmd("R9 flush line", 2, 0, 1, 5, 0, 7*SETS + 40, 0);
    run_cmd("R9 flush var",  2, 0, 1, 5, 0, VBASE, 0);
    refill(10);
    run_cmd("R13 flush past end", 2, 0, 1, 5, 0, TOTAL + 10, 0);
    run_cmd("R13 clr past end",   1, 0, 1, 5, 0, (1 << AW) - 1, 0);
    run_cmd("R12 busy ignore",    2, 0, 1, 5, 0, 41, 1);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule